// File: doc/BRIEF.md
# Writable Microcode Sequencer with Opcode Paging

This block steps through a writable control store of 32-bit micro-words and drives a datapath from the fields of the word it is executing. The macro opcode is used directly as a page number, with no decode logic. A micro-address is the page number followed by an offset, and each page holds 16 micro-words. A micro-instruction register sits between the store and the field outputs. Every word therefore spends one cycle being fetched and one being executed, so the word that follows a redirecting word always runs.

The next micro-address comes from the word being executed. Its two-bit next-address field selects one of four moves: step the offset, jump to a target offset, branch on one of eight condition flags, or dispatch to offset zero of the page named by the incoming opcode. Two further bits act on the page. One moves to the following page, so a long routine can continue past its own page. The other requests the next macro-instruction and loads its opcode as the page. A host write port loads the store, and it only takes effect while the sequencer is held in reset.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the micro-address becomes page 0, offset 0, and the executing word becomes all zeros, so every control output reads 0.
- R2: A word with next-address code 00 and no page bits set makes the fetch offset step by one within the same page, wrapping from 15 to 0.
- R3: Code 01 loads the fetch offset from the target field (word bits 15:12).
- R4: Code 10 loads the target offset if `flags_i[sel]` is 1, where sel is word bits 26:24; otherwise the offset steps by one. No other flag bit has any effect.
- R5: A redirect takes effect one cycle after the redirecting word enters the micro-instruction register, so the word stored directly after it always executes.
- R6: Code 11 sets the offset to 0 and the page to `opcode_i`. `fetch_o` is high exactly while the executing word has bit 30 set, and that bit also loads `opcode_i` as the page.
- R7: Word bit 29, when no opcode load is requested, adds one to the page, combined with the offset chosen by the next-address code.
- R8: While a word executes, its bits 3:0, 7:4, 9:8, 11:10, 23:16 and 31 appear on `bus_src_o`, `bus_dst_o`, `dsp_ctl_o`, `rsp_ctl_o`, `alu_fn_o` and `mar_inc_o`.
- R9: A host write lands in the control store only while `rst_n` is low. A write while running leaves the stored word unchanged.
- R10: `uaddr_o` is `{page, offset}`, and the word at that address enters the micro-instruction register at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; also enables host writes |
| opcode_i | input | OPC_W | Next macro opcode, used as a page number |
| flags_i | input | 8 | Condition flags from the datapath |
| wr_en_i | input | 1 | Host write strobe for the control store |
| wr_addr_i | input | OPC_W+4 | Host write micro-address |
| wr_data_i | input | 32 | Host write micro-word |
| uaddr_o | output | OPC_W+4 | Micro-address being fetched |
| fetch_o | output | 1 | Request for the next macro-instruction |
| bus_src_o | output | 4 | Bus source select |
| bus_dst_o | output | 4 | Bus destination select |
| dsp_ctl_o | output | 2 | Data stack pointer control |
| rsp_ctl_o | output | 2 | Return stack pointer control |
| alu_fn_o | output | 8 | ALU function field |
| mar_inc_o | output | 1 | Memory address increment |

## Verification
The bench builds the block with its default parameters: an 8-bit opcode and 16-word pages, which gives a 4096-word store. The full 9-bit opcode is set by the same parameter. These values let a short microprogram use four opcode pages, a jump to offset 14 followed by a page increment into the next page, and a dispatch back to page 0. The conditional branch is run once with only the selected flag high and once with every other flag high, which covers both branch directions and shows that the other flags are ignored.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
    localparam int WORD_W    = 32;
    localparam int FLAG_N    = 8;
    localparam int SEL_W     = 3;
    localparam int SRC_LSB   = 0;
    localparam int DST_LSB   = 4;
    localparam int DSP_LSB   = 8;
    localparam int RSP_LSB   = 10;
    localparam int TGT_LSB   = 12;
    localparam int ALU_LSB   = 16;
    localparam int SEL_LSB   = 24;
    localparam int NX_LSB    = 27;
    localparam int PINC_BIT  = 29;
    localparam int FETCH_BIT = 30;
    localparam int MINC_BIT  = 31;

    typedef enum logic [1:0] {
        NX_SEQ      = 2'b00,
        NX_JUMP     = 2'b01,
        NX_COND     = 2'b10,
        NX_DISPATCH = 2'b11
    } nx_mode_e;
endpackage

// File: rtl/useq_store.sv
`timescale 1ns/1ps
module useq_store #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/useq_fields.sv
`timescale 1ns/1ps
module useq_fields
    import useq_pkg::*;
#(
    parameter int OFF_W = 4
) (
    input  logic [WORD_W-1:0] word,
    output logic [3:0]        src,
    output logic [3:0]        dst,
    output logic [1:0]        dsp,
    output logic [1:0]        rsp,
    output logic [OFF_W-1:0]  tgt,
    output logic [7:0]        alu,
    output logic [SEL_W-1:0]  sel,
    output nx_mode_e          nx,
    output logic              pinc,
    output logic              fetch,
    output logic              minc
);
    always_comb begin
        src   = word[SRC_LSB +: 4];
        dst   = word[DST_LSB +: 4];
        dsp   = word[DSP_LSB +: 2];
        rsp   = word[RSP_LSB +: 2];
        tgt   = word[TGT_LSB +: OFF_W];
        alu   = word[ALU_LSB +: 8];
        sel   = word[SEL_LSB +: SEL_W];
        nx    = nx_mode_e'(word[NX_LSB +: 2]);
        pinc  = word[PINC_BIT];
        fetch = word[FETCH_BIT];
        minc  = word[MINC_BIT];
    end
endmodule

// File: rtl/useq_next.sv
`timescale 1ns/1ps
module useq_next
    import useq_pkg::*;
#(
    parameter int OPC_W = 8,
    parameter int OFF_W = 4
) (
    input  logic [OPC_W-1:0]  page_q,
    input  logic [OFF_W-1:0]  off_q,
    input  nx_mode_e          nx,
    input  logic [SEL_W-1:0]  sel,
    input  logic [OFF_W-1:0]  tgt,
    input  logic              pinc,
    input  logic              fetch,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [FLAG_N-1:0] flags,
    output logic [OPC_W-1:0]  page_n,
    output logic [OFF_W-1:0]  off_n
);
    logic             hit;
    logic [OFF_W-1:0] step;

    always_comb begin
        hit  = flags[sel];
        step = off_q + 1'b1;
        unique case (nx)
            NX_SEQ:      off_n = step;
            NX_JUMP:     off_n = tgt;
            NX_COND:     off_n = hit ? tgt : step;
            NX_DISPATCH: off_n = '0;
            default:     off_n = step;
        endcase
        if (fetch || nx == NX_DISPATCH) begin
            page_n = opcode;
        end else if (pinc) begin
            page_n = page_q + 1'b1;
        end else begin
            page_n = page_q;
        end
    end
endmodule

// File: rtl/useq_sequencer.sv
`timescale 1ns/1ps
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int OPC_W = 8,
    parameter int OFF_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [OPC_W-1:0]       opcode_i,
    input  logic [FLAG_N-1:0]      flags_i,
    input  logic                   wr_en_i,
    input  logic [OPC_W+OFF_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0]      wr_data_i,
    output logic [OPC_W+OFF_W-1:0] uaddr_o,
    output logic                   fetch_o,
    output logic [3:0]             bus_src_o,
    output logic [3:0]             bus_dst_o,
    output logic [1:0]             dsp_ctl_o,
    output logic [1:0]             rsp_ctl_o,
    output logic [7:0]             alu_fn_o,
    output logic                   mar_inc_o
);
    localparam int ADDR_W = OPC_W + OFF_W;

    typedef struct packed {
        logic [OPC_W-1:0]  page;
        logic [OFF_W-1:0]  off;
        logic [WORD_W-1:0] mir;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [WORD_W-1:0] store_rd;
    logic [WORD_W-1:0] mir_word;
    logic [OFF_W-1:0]  f_tgt;
    logic [SEL_W-1:0]  f_sel;
    nx_mode_e          f_nx;
    logic              f_pinc;
    logic              f_fetch;
    logic [OPC_W-1:0]  page_nx;
    logic [OFF_W-1:0]  off_nx;

    assign mir_word = state_q.mir;
    assign uaddr_o  = {state_q.page, state_q.off};
    assign fetch_o  = f_fetch;

    useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .we    (wr_en_i && !rst_n),
        .waddr (wr_addr_i),
        .wdata (wr_data_i),
        .raddr (uaddr_o),
        .rdata (store_rd)
    );

    useq_fields #(.OFF_W(OFF_W)) u_fields (
        .word  (mir_word),
        .src   (bus_src_o),
        .dst   (bus_dst_o),
        .dsp   (dsp_ctl_o),
        .rsp   (rsp_ctl_o),
        .tgt   (f_tgt),
        .alu   (alu_fn_o),
        .sel   (f_sel),
        .nx    (f_nx),
        .pinc  (f_pinc),
        .fetch (f_fetch),
        .minc  (mar_inc_o)
    );

    useq_next #(.OPC_W(OPC_W), .OFF_W(OFF_W)) u_next (
        .page_q (state_q.page),
        .off_q  (state_q.off),
        .nx     (f_nx),
        .sel    (f_sel),
        .tgt    (f_tgt),
        .pinc   (f_pinc),
        .fetch  (f_fetch),
        .opcode (opcode_i),
        .flags  (flags_i),
        .page_n (page_nx),
        .off_n  (off_nx)
    );

    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d.page = '0;
            state_d.off  = '0;
            state_d.mir  = '0;
        end else begin
            state_d.page = page_nx;
            state_d.off  = off_nx;
            state_d.mir  = store_rd;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end
endmodule

// File: rtl/useq_sequencer_chk.sv
`timescale 1ns/1ps
module useq_sequencer_chk #(
    parameter int OPC_W = 8,
    parameter int OFF_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [OPC_W-1:0]       opcode_i,
    input logic [7:0]             flags_i,
    input logic [OPC_W+OFF_W-1:0] uaddr_o,
    input logic [1:0]             nx,
    input logic [2:0]             sel,
    input logic [OFF_W-1:0]       tgt,
    input logic                   pinc,
    input logic                   fch
);
    logic [OFF_W-1:0] off_w;
    logic [OPC_W-1:0] page_w;
    assign off_w  = uaddr_o[OFF_W-1:0];
    assign page_w = uaddr_o[OPC_W+OFF_W-1:OFF_W];

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nx == 2'b00 && !pinc && !fch) |=>
        (off_w == $past(off_w) + 1'b1) && (page_w == $past(page_w)));

    // R3
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nx == 2'b01 && !fch) |=> (off_w == $past(tgt)));

    // R4
    cond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nx == 2'b10 && flags_i[sel] && !fch) |=> (off_w == $past(tgt)));

    // R4
    cond_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nx == 2'b10 && !flags_i[sel] && !fch) |=> (off_w == $past(off_w) + 1'b1));

    // R6
    dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nx == 2'b11) |=> (off_w == '0) && (page_w == $past(opcode_i)));

    // R7
    page_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pinc && !fch && nx != 2'b11) |=> (page_w == $past(page_w) + 1'b1));
endmodule

bind useq_sequencer useq_sequencer_chk #(.OPC_W(OPC_W), .OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode_i (opcode_i),
    .flags_i  (flags_i),
    .uaddr_o  (uaddr_o),
    .nx       (mir_word[28:27]),
    .sel      (mir_word[26:24]),
    .tgt      (mir_word[12 +: OFF_W]),
    .pinc     (mir_word[29]),
    .fch      (mir_word[30])
);

// File: tb/useq_sequencer_tb.sv
`timescale 1ns/1ps
module useq_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [7:0]  flags_i = '0;
    logic        wr_en_i = 1'b0;
    logic [11:0] wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [11:0] uaddr_o;
    logic        fetch_o;
    logic [3:0]  bus_src_o, bus_dst_o;
    logic [1:0]  dsp_ctl_o, rsp_ctl_o;
    logic [7:0]  alu_fn_o;
    logic        mar_inc_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    useq_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .flags_i(flags_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .uaddr_o(uaddr_o), .fetch_o(fetch_o), .bus_src_o(bus_src_o),
        .bus_dst_o(bus_dst_o), .dsp_ctl_o(dsp_ctl_o), .rsp_ctl_o(rsp_ctl_o),
        .alu_fn_o(alu_fn_o), .mar_inc_o(mar_inc_o)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [11:0] exp_t;
        logic [11:0] exp_n;
        logic        fch;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 12'h000, 12'h000, 1'b0},
        '{8'h00, 12'h001, 12'h001, 1'b0},
        '{8'h05, 12'h002, 12'h002, 1'b1},
        '{8'h00, 12'h050, 12'h050, 1'b0},
        '{8'h00, 12'h051, 12'h051, 1'b0},
        '{8'h00, 12'h054, 12'h054, 1'b0},
        '{8'h00, 12'h055, 12'h055, 1'b0},
        '{8'h06, 12'h056, 12'h056, 1'b1},
        '{8'h00, 12'h060, 12'h060, 1'b0},
        '{8'h00, 12'h061, 12'h061, 1'b0},
        '{8'h00, 12'h068, 12'h062, 1'b0},
        '{8'h07, 12'h069, 12'h063, 1'b1},
        '{8'h00, 12'h070, 12'h070, 1'b0},
        '{8'h00, 12'h071, 12'h071, 1'b0},
        '{8'h00, 12'h07E, 12'h07E, 1'b0},
        '{8'h00, 12'h07F, 12'h07F, 1'b0},
        '{8'h00, 12'h082, 12'h082, 1'b0},
        '{8'h00, 12'h083, 12'h083, 1'b1},
        '{8'h00, 12'h000, 12'h000, 1'b0},
        '{8'h00, 12'h001, 12'h001, 1'b0}
    };

    function automatic logic [31:0] mk(input logic [3:0] src, input logic [3:0] dst,
                                       input logic [1:0] dsp, input logic [1:0] rsp,
                                       input logic [3:0] tgt, input logic [7:0] alu,
                                       input logic [2:0] sel, input logic [1:0] nx,
                                       input logic pinc, input logic fch, input logic minc);
        return {minc, fch, pinc, nx, sel, alu, tgt, rsp, dsp, dst, src};
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            1:  return "R2";
            3:  return "R6";
            4:  return "R5";
            5:  return "R3";
            10: return "R4";
            16: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic run(input bit taken);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1 uaddr", {20'd0, uaddr_o}, 32'd0);
        chk("R1 ctl", {fetch_o, bus_src_o, bus_dst_o, dsp_ctl_o, rsp_ctl_o, alu_fn_o, mar_inc_o}, 32'd0);
        flags_i = taken ? 8'h04 : 8'hFB;
        rst_n = 1'b1;
        for (int s = 0; s < NV; s++) begin
            opcode_i = VEC[s].op;
            chk(tag_of(s), {20'd0, uaddr_o}, {20'd0, taken ? VEC[s].exp_t : VEC[s].exp_n});
            chk("R6 fetch", {31'd0, fetch_o}, {31'd0, VEC[s].fch});
            if (s == 1) chk(taken ? "R8 src" : "R9 src kept", {28'd0, bus_src_o}, 32'd1);
            if (s == 6) chk("R8 fields", {bus_src_o, bus_dst_o, dsp_ctl_o, rsp_ctl_o, alu_fn_o},
                            {4'h5, 4'hA, 2'd2, 2'd1, 8'h3C});
            if (s == 14) chk("R8 minc low", {31'd0, mar_inc_o}, 32'd0);
            if (s == 15) chk("R8 minc", {31'd0, mar_inc_o}, 32'd1);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        // microprogram, loaded while held in reset (R9)
        wr(12'h000, mk(4'h1, 4'h0, 2'd0, 2'd0, 4'h0, 8'h00, 3'd0, 2'b00, 1'b0, 1'b0, 1'b0));
        wr(12'h001, mk(4'h0, 4'h0, 2'd0, 2'd0, 4'h0, 8'h00, 3'd0, 2'b11, 1'b0, 1'b1, 1'b0));
        wr(12'h002, mk(4'h2, 4'h0, 2'd0, 2'd0, 4'h0, 8'h00, 3'd0, 2'b00, 1'b0, 1'b0, 1'b0));
        wr(12'h050, mk(4'h3, 4'h0, 2'd0, 2'd0, 4'h4, 8'h00, 3'd0, 2'b01, 1'b0, 1'b0, 1'b0));
        wr(12'h051, mk(4'h4, 4'h0, 2'd0, 2'd0, 4'h0, 8'h00, 3'd0, 2'b00, 1'b0, 1'b0, 1'b0));
        wr(12'h054, mk(4'h5, 4'hA, 2'd2, 2'd1, 4'h0, 8'h3C, 3'd0, 2'b00, 1'b0, 1'b0, 1'b0));
        wr(12'h055, mk(4'h0, 4'h0, 2'd0, 2'd0, 4'h0, 8'h00, 3'd0, 2'b11, 1'b0, 1'b1, 1'b0));
        wr(12'h056, 32'd0);
        wr(12'h060, mk(4'h0, 4'h0, 2'd0, 2'd0, 4'h8, 8'h00, 3'd2, 2'b10, 1'b0, 1'b0, 1'b0));
        wr(12'h061, 32'd0);
        wr(12'h062, mk(4'h0, 4'h0, 2'd0, 2'd0, 4'h0, 8'h00, 3'd0, 2'b11, 1'b0, 1'b1, 1'b0));
        wr(12'h063, 32'd0);
        wr(12'h068, mk(4'h0, 4'h0, 2'd0, 2'd0, 4'h0, 8'h00, 3'd0, 2'b11, 1'b0, 1'b1, 1'b0));
        wr(12'h069, 32'd0);
        wr(12'h070, mk(4'h0, 4'h0, 2'd0, 2'd0, 4'hE, 8'h00, 3'd0, 2'b01, 1'b0, 1'b0, 1'b0));
        wr(12'h071, 32'd0);
        wr(12'h07E, mk(4'h0, 4'h0, 2'd0, 2'd0, 4'h2, 8'h00, 3'd0, 2'b01, 1'b1, 1'b0, 1'b1));
        wr(12'h07F, 32'd0);
        wr(12'h082, mk(4'h0, 4'h0, 2'd0, 2'd0, 4'h0, 8'h00, 3'd0, 2'b11, 1'b0, 1'b1, 1'b0));
        wr(12'h083, 32'd0);

        // taken branch on selected flag only
        run(1'b1);
        // R9: write while running must not land
        wr(12'h000, mk(4'h9, 4'h0, 2'd0, 2'd0, 4'h0, 8'h00, 3'd0, 2'b00, 1'b0, 1'b0, 1'b0));
        // fall-through with every other flag high (R4)
        run(1'b0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule